// File: doc/BRIEF.md
# Coherent Byte-Access Channel Value Buffer

This block lets an 8-bit bus read and write a 16-bit timer channel value without tearing. The bus reaches the word one byte at a time through a high-byte select and a low-byte select, with separate read and write strobes. A mode input says whether the channel is capturing, in which case the word is read-only and comes from a live 16-bit capture value, or comparing/generating PWM, in which case the word is written by software and drives the committed channel value.

In capture mode the first byte read freezes the whole live word in a snapshot, and the other byte is then read from that snapshot. Once the other byte has been read, the snapshot is released. In compare mode the first byte written is staged. The committed value changes only when the other byte arrives, and both bytes then land together. A write to the channel control register, or any change of the mode input, abandons a half-finished access in either direction.

Top module: `chan_val_buf`

## Requirements
- R1: After reset `chan_val_o` is 0, no read snapshot is held and no byte is staged.
- R2: In capture mode, a read with no snapshot held returns the selected byte of `cap_val_i` in the same cycle and freezes all 16 bits of `cap_val_i` as the snapshot. The high byte is bits 15:8 and the low byte is bits 7:0.
- R3: While a snapshot is held, a read of the byte opposite to the one that took it returns that byte from the snapshot, whatever `cap_val_i` has since become, and releases the snapshot. The next read then takes a fresh one.
- R4: While a snapshot is held, reading again the byte that took it returns the snapshot byte and keeps the snapshot held.
- R5: In compare mode, a write of one byte with nothing staged stages it and leaves `chan_val_o` unchanged.
- R6: In compare mode, writing the opposite byte to the staged one updates all 16 bits of `chan_val_o` at once, on the clock edge that ends the write cycle, in either byte order.
- R7: Writing the staged byte again before the other one arrives replaces the staged value and commits nothing.
- R8: A `ctrl_wr_i` pulse drops any held snapshot and any staged byte. A byte access in the same cycle as the pulse is ignored.
- R9: A change of `capture_mode_i` drops any held snapshot and any staged byte.
- R10: Writes in capture mode have no effect. Reads in compare mode return the selected byte of `chan_val_o` and take no snapshot.
- R11: An access counts only with exactly one of `sel_hi_i` and `sel_lo_i` set. `rdata_o` is 0 in any cycle that has no counted read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| capture_mode_i | input | 1 | 1 = capture, 0 = compare/PWM |
| sel_hi_i | input | 1 | Selects byte bits 15:8 |
| sel_lo_i | input | 1 | Selects byte bits 7:0 |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write byte |
| rdata_o | output | 8 | Read byte, valid in the strobe cycle |
| cap_val_i | input | 16 | Live captured value |
| ctrl_wr_i | input | 1 | Channel control register write |
| chan_val_o | output | 16 | Committed channel value |

## Verification
On every cycle the assertions check four things: the committed value never moves while in capture mode, it moves only after a counted write, a control write or a mode change leaves nothing latched or staged, and the two staging flags are never set together. Only the bench scenarios can show the data coherence itself. These scenarios cover snapshot bytes that ignore a changed live value, release after the opposite byte, a fresh snapshot afterwards, pair commits in both orders, overwrite of a staged byte, and accesses that are aborted or ignored.

// File: rtl/chan_buf_pkg.sv
package chan_buf_pkg;
  typedef enum logic [1:0] {SEL_NONE, SEL_HI, SEL_LO, SEL_BAD} byte_sel_e;

  function automatic byte_sel_e decode_sel(input logic hi, input logic lo);
    case ({hi, lo})
      2'b10:   return SEL_HI;
      2'b01:   return SEL_LO;
      2'b11:   return SEL_BAD;
      default: return SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/chan_rd_latch.sv
module chan_rd_latch #(
  parameter int BYTE_W = 8,
  localparam int WORD_W = 2 * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              rd_i,
  input  logic              sel_hi_i,
  input  logic [WORD_W-1:0] live_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic              latched_o
);
  logic [WORD_W-1:0] snap_q;
  logic              latched_q;
  logic              first_hi_q;
  logic [WORD_W-1:0] word;

  assign word      = latched_q ? snap_q : live_i;
  assign byte_o    = sel_hi_i ? word[WORD_W-1:BYTE_W] : word[BYTE_W-1:0];
  assign latched_o = latched_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      snap_q     <= '0;
      latched_q  <= 1'b0;
      first_hi_q <= 1'b0;
    end else if (clr_i) begin
      latched_q <= 1'b0;
    end else if (rd_i) begin
      if (!latched_q) begin
        snap_q     <= live_i;
        latched_q  <= 1'b1;
        first_hi_q <= sel_hi_i;
      end else if (sel_hi_i != first_hi_q) begin
        latched_q <= 1'b0;  // opposite byte read: release
      end
    end
  end
endmodule

// File: rtl/chan_wr_stage.sv
module chan_wr_stage #(
  parameter int BYTE_W = 8,
  localparam int WORD_W = 2 * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              wr_i,
  input  logic              sel_hi_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [WORD_W-1:0] val_o,
  output logic              hi_staged_o,
  output logic              lo_staged_o
);
  logic [BYTE_W-1:0] stage_hi_q, stage_lo_q;
  logic              hi_staged_q, lo_staged_q;
  logic [WORD_W-1:0] val_q;

  assign val_o       = val_q;
  assign hi_staged_o = hi_staged_q;
  assign lo_staged_o = lo_staged_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_hi_q  <= '0;
      stage_lo_q  <= '0;
      hi_staged_q <= 1'b0;
      lo_staged_q <= 1'b0;
      val_q       <= '0;
    end else if (clr_i) begin
      hi_staged_q <= 1'b0;
      lo_staged_q <= 1'b0;
    end else if (wr_i) begin
      if (sel_hi_i) begin
        if (lo_staged_q) begin
          val_q       <= {wdata_i, stage_lo_q};
          lo_staged_q <= 1'b0;
        end else begin
          stage_hi_q  <= wdata_i;
          hi_staged_q <= 1'b1;
        end
      end else begin
        if (hi_staged_q) begin
          val_q       <= {stage_hi_q, wdata_i};
          hi_staged_q <= 1'b0;
        end else begin
          stage_lo_q  <= wdata_i;
          lo_staged_q <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/chan_val_buf.sv
module chan_val_buf
  import chan_buf_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int WORD_W = 2 * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              capture_mode_i,
  input  logic              sel_hi_i,
  input  logic              sel_lo_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] rdata_o,
  input  logic [WORD_W-1:0] cap_val_i,
  input  logic              ctrl_wr_i,
  output logic [WORD_W-1:0] chan_val_o
);
  byte_sel_e         sel;
  logic              one_sel, mode_q, mode_chg, clr;
  logic              cap_rd, cmp_wr;
  logic              rd_latched, hi_staged, lo_staged;
  logic [BYTE_W-1:0] cap_byte, cmp_byte;

  assign sel      = decode_sel(sel_hi_i, sel_lo_i);
  assign one_sel  = (sel == SEL_HI) || (sel == SEL_LO);
  assign mode_chg = capture_mode_i != mode_q;
  assign clr      = ctrl_wr_i | mode_chg;
  assign cap_rd   = rd_i & capture_mode_i & one_sel & ~clr;
  assign cmp_wr   = wr_i & ~capture_mode_i & one_sel & ~clr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= 1'b0;
    else         mode_q <= capture_mode_i;
  end

  chan_rd_latch #(.BYTE_W(BYTE_W)) u_rd (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (clr),
    .rd_i      (cap_rd),
    .sel_hi_i  (sel == SEL_HI),
    .live_i    (cap_val_i),
    .byte_o    (cap_byte),
    .latched_o (rd_latched)
  );

  chan_wr_stage #(.BYTE_W(BYTE_W)) u_wr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (clr),
    .wr_i        (cmp_wr),
    .sel_hi_i    (sel == SEL_HI),
    .wdata_i     (wdata_i),
    .val_o       (chan_val_o),
    .hi_staged_o (hi_staged),
    .lo_staged_o (lo_staged)
  );

  assign cmp_byte = (sel == SEL_HI) ? chan_val_o[WORD_W-1:BYTE_W] : chan_val_o[BYTE_W-1:0];

  always_comb begin
    rdata_o = '0;
    if (rd_i && one_sel) rdata_o = capture_mode_i ? cap_byte : cmp_byte;
  end
endmodule

// File: rtl/chan_val_buf_chk.sv
module chan_val_buf_chk #(
  parameter int BYTE_W = 8,
  localparam int WORD_W = 2 * BYTE_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              capture_mode_i,
  input logic              wr_i,
  input logic              ctrl_wr_i,
  input logic [WORD_W-1:0] chan_val_o,
  input logic              rd_latched,
  input logic              hi_staged,
  input logic              lo_staged
);
  assert_capture_holds_val_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(capture_mode_i) |-> $stable(chan_val_o));

  assert_change_needs_write_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chan_val_o != $past(chan_val_o)) |-> $past(wr_i && !ctrl_wr_i));

  assert_ctrl_clears_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wr_i |=> !(rd_latched || hi_staged || lo_staged));

  assert_mode_clears_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (capture_mode_i != $past(capture_mode_i)) |=> !(rd_latched || hi_staged || lo_staged));

  assert_one_side_staged_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hi_staged && lo_staged));
endmodule

bind chan_val_buf chan_val_buf_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .capture_mode_i (capture_mode_i),
  .wr_i           (wr_i),
  .ctrl_wr_i      (ctrl_wr_i),
  .chan_val_o     (chan_val_o),
  .rd_latched     (rd_latched),
  .hi_staged      (hi_staged),
  .lo_staged      (lo_staged)
);

// File: tb/chan_val_buf_bench.sv
module chan_val_buf_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        capture_mode_i = 1'b1;
  logic        sel_hi_i = 1'b0, sel_lo_i = 1'b0, rd_i = 1'b0, wr_i = 1'b0, ctrl_wr_i = 1'b0;
  logic [7:0]  wdata_i = '0;
  logic [7:0]  rdata_o;
  logic [15:0] cap_val_i = '0;
  logic [15:0] chan_val_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2 clk_i = ~clk_i;

  chan_val_buf u_chan_val_buf (.*);

  task automatic report(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk_i);
    {sel_hi_i, sel_lo_i, rd_i, wr_i, ctrl_wr_i} = '0;
  endtask

  task automatic rd_op(input bit hi, input bit lo, input logic [7:0] exp, input string tag);
    @(negedge clk_i);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    {sel_hi_i, sel_lo_i, rd_i, wr_i, ctrl_wr_i} = {hi, lo, 1'b1, 1'b0, 1'b0};
    idle();
  endtask

  task automatic wr_op(input bit hi, input logic [7:0] d, input bit ctrl);
    @(negedge clk_i);
    wdata_i = d;
    {sel_hi_i, sel_lo_i, rd_i, wr_i, ctrl_wr_i} = {hi, ~hi, 1'b0, 1'b1, ctrl};
    idle();
  endtask

  task automatic ctrl_op();
    @(negedge clk_i);
    ctrl_wr_i = 1'b1;
    idle();
  endtask

  task automatic set_mode(input bit m);
    @(negedge clk_i);
    capture_mode_i = m;
    idle();
  endtask

  task automatic chk_val(input logic [15:0] exp, input string tag);
    #1 report(chan_val_o === exp, tag, chan_val_o, exp);
  endtask

  // monitor: scoreboard for read data
  initial begin
    forever begin
      @(negedge clk_i);
      #1;
      if (rd_i) begin
        if (exp_q.size() == 0) report(1'b0, "unexpected read", {8'h0, rdata_o}, 16'h0);
        else begin
          automatic logic [7:0] e = exp_q.pop_front();
          automatic string t = tag_q.pop_front();
          report(rdata_o === e, t, {8'h0, rdata_o}, {8'h0, e});
        end
      end
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    idle();
    chk_val(16'h0000, "R1 reset value");
    #1 report(rdata_o === 8'h00, "R11 idle rdata", {8'h0, rdata_o}, 16'h0);

    // capture mode snapshot
    cap_val_i = 16'hA1B2;
    rd_op(1, 0, 8'hA1, "R2 live hi + snapshot");
    cap_val_i = 16'h3C4D;
    rd_op(0, 1, 8'hB2, "R3 lo from snapshot");
    rd_op(0, 1, 8'h4D, "R3 fresh after release");
    cap_val_i = 16'h5E6F;
    rd_op(0, 1, 8'h4D, "R4 same byte reread");
    rd_op(1, 0, 8'h3C, "R3 hi releases");
    rd_op(1, 0, 8'h5E, "R2 fresh snapshot hi");
    cap_val_i = 16'h7788;
    ctrl_op();
    rd_op(0, 1, 8'h88, "R8 ctrl dropped snapshot");
    cap_val_i = 16'h99AA;
    rd_op(1, 1, 8'h00, "R11 both selects no read");
    rd_op(1, 0, 8'h77, "R11 snapshot kept");
    wr_op(1, 8'h12, 0);
    wr_op(0, 8'h34, 0);
    chk_val(16'h0000, "R10 capture write ignored");

    // mode change drops snapshot
    rd_op(1, 0, 8'h99, "R2 snapshot before mode change");
    set_mode(0);
    set_mode(1);
    idle();
    cap_val_i = 16'hBBCC;
    rd_op(0, 1, 8'hCC, "R9 snapshot dropped");
    rd_op(1, 0, 8'hBB, "R3 release");

    // compare mode staging
    set_mode(0);
    idle();
    wr_op(1, 8'h12, 0);
    chk_val(16'h0000, "R5 single byte staged");
    wr_op(0, 8'h34, 0);
    chk_val(16'h1234, "R6 hi then lo");
    wr_op(0, 8'h56, 0);
    chk_val(16'h1234, "R5 lo staged");
    wr_op(1, 8'h78, 0);
    chk_val(16'h7856, "R6 lo then hi");
    wr_op(1, 8'h11, 0);
    wr_op(1, 8'h22, 0);
    chk_val(16'h7856, "R7 repeat hi no commit");
    wr_op(0, 8'h33, 0);
    chk_val(16'h2233, "R7 overwritten hi used");
    wr_op(0, 8'h44, 0);
    ctrl_op();
    wr_op(1, 8'h55, 0);
    chk_val(16'h2233, "R8 staged lo dropped");
    wr_op(0, 8'h66, 0);
    chk_val(16'h5566, "R8 new pair");
    wr_op(1, 8'h77, 0);
    set_mode(1);
    set_mode(0);
    idle();
    wr_op(0, 8'h88, 0);
    chk_val(16'h5566, "R9 staged hi dropped");
    wr_op(1, 8'h99, 0);
    chk_val(16'h9988, "R9 new pair");
    cap_val_i = 16'hDEAD;
    rd_op(1, 0, 8'h99, "R10 compare read hi");
    rd_op(0, 1, 8'h88, "R10 compare read lo");
    wr_op(1, 8'hAA, 1);
    wr_op(0, 8'hBB, 0);
    chk_val(16'h9988, "R8 write with ctrl ignored");
    wr_op(1, 8'hCC, 0);
    chk_val(16'hCCBB, "R8 pair after ignored write");

    repeat (2) idle();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule